// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block looks after the refresh needs of a 4M x 1 dynamic RAM that shares its strobes with a data-path controller. After reset it holds off for the power-up pause. It then asks for the bus and runs a burst of warm-up refresh cycles. Only after that burst does it flag the memory as ready. From then on it raises one refresh demand per refresh interval, so that 1024 rows are covered every 16 ms.

Every refresh is a CAS-before-RAS cycle, so the row address comes from the counter inside the memory. The scheduler drives the strobes only while it owns the bus. A grant lets it run its whole cycle, including precharge. If the controller holds off the grant, the owed refreshes are counted. They are then issued back to back as soon as the bus arrives.

All times are counted in clock cycles. The default values assume a 100 MHz clock. Write enable is tied high, so a refresh can never turn into a test-mode entry.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, and for exactly PAUSE_CYC cycles after its release, ras_n_o, cas_n_o and we_n_o are high and bus_req_o, bus_own_o and init_done_o are low.
- R2: After the pause the block requests the bus. Once granted, it runs exactly INIT_CBR refresh cycles without dropping bus_own_o. init_done_o rises in the same cycle that bus_own_o falls.
- R3: cas_n_o is low for exactly T_CSR cycles before ras_n_o falls, and stays low for the whole time ras_n_o is low.
- R4: ras_n_o stays low for exactly T_RAS cycles. Within one ownership period, both strobes stay high for exactly T_RP cycles before cas_n_o falls again.
- R5: we_n_o is high in every cycle.
- R6: bus_req_o, once raised, stays high until bus_gnt_i is seen. While the bus is not owned, both strobes stay high.
- R7: After init_done_o rises, one refresh is owed every REFI_CYC cycles. With the grant always present, successive falls of ras_n_o are exactly REFI_CYC cycles apart.
- R8: Refreshes owed while the grant is withheld are counted. On the next grant they are all issued, back to back, within one ownership period.
- R9: The count of owed refreshes saturates at 2^DEBT_W - 1 and never wraps.
- R10: Once high, init_done_o stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_gnt_i | input | 1 | Grant from the data-path controller |
| bus_req_o | output | 1 | Bus request, held until granted |
| bus_own_o | output | 1 | High while the block drives the strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, held high |
| init_done_o | output | 1 | Memory initialized and ready |

## Verification
The next-state logic has three places where a wrong internal state can go wrong, and each one becomes visible on the ports.

- A wrong phase counter shows up at once, at the next strobe edge: a setup, strobe or precharge width is off by some cycles.
- A wrong warm-up count moves the rise of the ready flag. This is seen the moment the flag rises, by comparing it with the number of row-strobe falls.
- A wrong debt count changes the length of the next catch-up burst. Each burst is counted from the outside with the grant withheld for a known number of intervals, including a run long enough to reach saturation.

// File: rtl/drs_pkg.sv
package drs_pkg;
    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_PRECH
    } drs_state_e;
endpackage

// File: rtl/drs_interval.sv
module drs_interval #(
    parameter int PERIOD = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int TW = $clog2(PERIOD + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (run_i) begin
            if (cnt_q == '0) cnt_d = TW'(PERIOD - 1);
            else             cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= TW'(PERIOD - 1);
        else        cnt_q <= cnt_d;
    end

    assign tick_o = run_i && (cnt_q == '0);

    // R7: two ticks can never fall in adjacent cycles
    a_r7_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/drs_debt.sv
module drs_debt #(
    parameter int DEBT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add_i,
    input  logic take_i,
    output logic owed_o
);
    localparam logic [DEBT_W-1:0] DMAX = {DEBT_W{1'b1}};

    logic [DEBT_W-1:0] debt_d, debt_q;

    always_comb begin
        debt_d = debt_q;
        unique case ({add_i, take_i})
            2'b10:   if (debt_q != DMAX) debt_d = debt_q + 1'b1;
            2'b01:   if (debt_q != '0)   debt_d = debt_q - 1'b1;
            default: debt_d = debt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) debt_q <= '0;
        else        debt_q <= debt_d;
    end

    assign owed_o = (debt_q != '0);

    // R9: a full counter stays full when more is added
    a_r9_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (debt_q == DMAX && add_i && !take_i) |=> debt_q == DMAX);
    // R8: the sequencer only retires a refresh that is owed
    a_r8_take_when_owed: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> owed_o);
endmodule

// File: rtl/drs_cbr_seq.sv
module drs_cbr_seq
    import drs_pkg::*;
#(
    parameter int PAUSE_CYC = 10000,
    parameter int INIT_CBR  = 8,
    parameter int T_CSR     = 1,
    parameter int T_RAS     = 6,
    parameter int T_RP      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gnt_i,
    input  logic owed_i,
    output logic req_o,
    output logic own_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic take_o,
    output logic done_o
);
    localparam int M1   = (T_RAS > T_RP) ? T_RAS : T_RP;
    localparam int M2   = (M1 > T_CSR) ? M1 : T_CSR;
    localparam int MAXC = (PAUSE_CYC > M2) ? PAUSE_CYC : M2;
    localparam int CW   = $clog2(MAXC + 1);
    localparam int IW   = $clog2(INIT_CBR + 1);

    typedef struct packed {
        drs_state_e     st;
        logic [CW-1:0]  cnt;
        logic [IW-1:0]  init_left;
        logic           done;
    } seq_t;

    seq_t d, q;
    logic warm;

    assign warm = (q.init_left != '0);

    always_comb begin
        d      = q;
        take_o = 1'b0;
        unique case (q.st)
            ST_PAUSE: begin
                if (q.cnt == '0) d.st = ST_IDLE;
                else             d.cnt = q.cnt - 1'b1;
            end
            ST_IDLE: begin
                if ((warm || owed_i) && gnt_i) begin
                    d.st  = ST_SETUP;
                    d.cnt = CW'(T_CSR - 1);
                end
            end
            ST_SETUP: begin
                if (q.cnt == '0) begin
                    d.st  = ST_STROBE;
                    d.cnt = CW'(T_RAS - 1);
                end else d.cnt = q.cnt - 1'b1;
            end
            ST_STROBE: begin
                if (q.cnt == '0) begin
                    d.st  = ST_PRECH;
                    d.cnt = CW'(T_RP - 1);
                    if (warm) d.init_left = q.init_left - 1'b1;
                    else      take_o = 1'b1;
                end else d.cnt = q.cnt - 1'b1;
            end
            ST_PRECH: begin
                if (q.cnt == '0) begin
                    if (warm || owed_i) begin
                        d.st  = ST_SETUP;
                        d.cnt = CW'(T_CSR - 1);
                    end else d.st = ST_IDLE;
                    if (!warm) d.done = 1'b1;
                end else d.cnt = q.cnt - 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st        <= ST_PAUSE;
            q.cnt       <= CW'(PAUSE_CYC - 1);
            q.init_left <= IW'(INIT_CBR);
            q.done      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign req_o   = (q.st == ST_IDLE) && (warm || owed_i);
    assign own_o   = (q.st == ST_SETUP) || (q.st == ST_STROBE) || (q.st == ST_PRECH);
    assign ras_n_o = (q.st != ST_STROBE);
    assign cas_n_o = !((q.st == ST_SETUP) || (q.st == ST_STROBE));
    assign done_o  = q.done;

    // R3: column strobe already low in the cycle before the row strobe falls
    a_r3_cas_leads: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> $past(!cas_n_o));
    // R3: column strobe held low for the whole row-strobe pulse
    a_r3_cas_covers: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n_o |-> !cas_n_o);
    // R4: precharge follows the end of the row-strobe pulse
    a_r4_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o) |=> (ras_n_o && cas_n_o && own_o));
    // R6: request held until granted
    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !gnt_i) |=> req_o);
    // R6: no strobe activity without owning the bus
    a_r6_quiet_unowned: assert property (@(posedge clk) disable iff (!rst_n)
        !own_o |-> (ras_n_o && cas_n_o));
    // R10: ready flag is sticky
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int PAUSE_CYC = 10000,
    parameter int INIT_CBR  = 8,
    parameter int REFI_CYC  = 1560,
    parameter int DEBT_W    = 3,
    parameter int T_CSR     = 1,
    parameter int T_RAS     = 6,
    parameter int T_RP      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_gnt_i,
    output logic bus_req_o,
    output logic bus_own_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic we_n_o,
    output logic init_done_o
);
    logic tick, owed, take, done;

    drs_interval #(.PERIOD(REFI_CYC)) u_interval (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (done),
        .tick_o (tick)
    );

    drs_debt #(.DEBT_W(DEBT_W)) u_debt (
        .clk    (clk),
        .rst_n  (rst_n),
        .add_i  (tick),
        .take_i (take),
        .owed_o (owed)
    );

    drs_cbr_seq #(
        .PAUSE_CYC (PAUSE_CYC),
        .INIT_CBR  (INIT_CBR),
        .T_CSR     (T_CSR),
        .T_RAS     (T_RAS),
        .T_RP      (T_RP)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .gnt_i   (bus_gnt_i),
        .owed_i  (owed),
        .req_o   (bus_req_o),
        .own_o   (bus_own_o),
        .ras_n_o (ras_n_o),
        .cas_n_o (cas_n_o),
        .take_o  (take),
        .done_o  (done)
    );

    assign we_n_o      = 1'b1;
    assign init_done_o = done;
endmodule

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps
module sim_dram_refresh_sched;
    localparam int PAUSE = 300;
    localparam int NINIT = 8;
    localparam int REFI  = 150;
    localparam int DW    = 3;
    localparam int TCSR  = 1;
    localparam int TRAS  = 6;
    localparam int TRP   = 4;
    localparam int DMAX  = (1 << DW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt = 1'b0;
    logic req, own, ras_n, cas_n, we_n, done;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dram_refresh_sched #(
        .PAUSE_CYC(PAUSE), .INIT_CBR(NINIT), .REFI_CYC(REFI), .DEBT_W(DW),
        .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bus_gnt_i(gnt), .bus_req_o(req),
        .bus_own_o(own), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
        .init_done_o(done)
    );

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // port monitor, sampled 2 ns after each rising edge
    int  cyc = 0, falls = 0, last_fall = 0, prev_fall = 0;
    int  cas_run = 0, ras_run = 0, pre_run = 0;
    bit  p_ras = 1'b1, p_cas = 1'b1, p_done = 1'b0, pre_ok = 1'b0;
    bit  we_bad = 1'b0, done_fell = 1'b0, cover_bad = 1'b0, mon_on = 1'b0;

    always @(posedge clk) begin
        #2;
        cyc++;
        if (mon_on) begin
            if (!we_n) we_bad = 1'b1;
            if (p_done && !done) done_fell = 1'b1;
            if (!ras_n && cas_n) cover_bad = 1'b1;
            if (p_ras && !ras_n) begin
                falls++;
                prev_fall = last_fall;
                last_fall = cyc;
                check("R3 cas setup cycles", cas_run == TCSR, cas_run, TCSR);
            end
            if (!p_ras && ras_n) begin
                check("R4 ras low cycles", ras_run == TRAS, ras_run, TRAS);
                pre_ok = 1'b1;
            end
            if (p_cas && !cas_n && pre_ok)
                check("R4 precharge cycles", pre_run == TRP, pre_run, TRP);
            if (!own) pre_ok = 1'b0;
            cas_run = (!cas_n && ras_n) ? cas_run + 1 : 0;
            ras_run = !ras_n ? ras_run + 1 : 0;
            pre_run = (ras_n && cas_n) ? pre_run + 1 : 0;
            p_ras = ras_n;
            p_cas = cas_n;
            p_done = done;
        end
    end

    task automatic step();
        @(posedge clk);
        #3;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        gnt = 1'b0;
        repeat (4) step();
        check("R1 reset strobes high", ras_n && cas_n && we_n, {ras_n, cas_n, we_n}, 7);
        check("R1 reset req/own/done low", !req && !own && !done, {req, own, done}, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        mon_on = 1'b1;
    endtask

    task automatic t_init();
        int n = 0;
        int f0;
        bit seen_own = 1'b0, own_gap = 1'b0, early = 1'b0;
        forever begin
            step();
            n++;
            if (req) break;
            if (own || !ras_n || !cas_n || done) early = 1'b1;
        end
        check("R1 pause length", n == PAUSE, n, PAUSE);
        check("R1 quiet during pause", !early, early, 0);
        f0 = falls;
        gnt = 1'b1;
        while (!done) begin
            step();
            if (own) seen_own = 1'b1;
            else if (seen_own && !done) own_gap = 1'b1;
        end
        check("R2 warm-up cycle count", (falls - f0) == NINIT, falls - f0, NINIT);
        check("R2 bus held through warm-up", !own_gap && seen_own, own_gap, 0);
        check("R2 own drops with ready", !own, own, 0);
    endtask

    task automatic t_periodic();
        int f0 = falls;
        while (falls < f0 + 2) step();
        check("R7 refresh spacing", (last_fall - prev_fall) == REFI, last_fall - prev_fall, REFI);
        while (own) step();
    endtask

    task automatic burst(input int waits, input int expect_n, input string tag);
        int f0;
        bit held = 1'b1;
        gnt = 1'b0;
        while (!req) step();
        repeat (waits) begin
            step();
            if (!req || own || !ras_n || !cas_n) held = 1'b0;
        end
        check("R6 request held, bus idle", held, held, 1);
        f0 = falls;
        gnt = 1'b1;
        while (!own) step();
        while (own) step();
        check(tag, (falls - f0) == expect_n, falls - f0, expect_n);
    endtask

    task automatic finish_run();
        check("R5 we stays high", !we_bad, we_bad, 0);
        check("R3 cas covers ras", !cover_bad, cover_bad, 0);
        check("R10 ready stays high", done && !done_fell, done_fell, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #3_000_000;
        check("watchdog", 1'b0, 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_init();
        t_periodic();
        burst(2 * REFI + 5, 3, "R8 catch-up burst of three");
        burst(10 * REFI + 5, DMAX, "R9 saturated burst");
        finish_run();
    end
endmodule